// File: doc/BRIEF.md
# Throttle Priority Arbiter

This block resolves simultaneous throttle requests into one set of clock-throttle settings. Three event sources feed it: index 0 is the light thermal event, index 1 is the heavy thermal event and index 2 is the overcurrent channel. Each source holds three values set by software: a priority, a CPU throttle depth in percent and a GPU throttle level. Each cycle the block considers the sources whose active flag is high and whose priority is nonzero. It picks the one with the largest priority and forwards that source's settings, together with its index and an active indication.

Settings arrive on a single-beat write channel with valid/ready. Ready is held high at all times after reset, so the channel never applies back-pressure. A beat is accepted on every clock edge at which valid is high, and the source needs no buffering. The outputs are plain registered levels and carry no handshake. Temperature measurement, the actual clock gating and the policy that chooses the settings are handled elsewhere.

Top module: `thr_arb_top`

## Requirements
- R1: After reset, all outputs are zero (`thr_active` low, `sel_idx` 0, `cpu_pct` 0, `gpu_lvl` 0), and every source has priority 0, so no throttle appears until software configures one.
- R2: `cfg_ready` is high whenever reset is released, and a write takes effect at each clock edge where `cfg_valid` is high. `cfg_field` selects the target: 0 is priority, 1 is CPU depth, 2 is GPU level. A write with `cfg_field` equal to 3, or with `cfg_evt` of 3 or more, changes nothing.
- R3: Priority writes saturate, so any value above 100 is stored as 100. A stored priority of 0 removes that source from arbitration even when its active flag is high.
- R4: CPU depth writes saturate at 100, and `cpu_pct` never exceeds 100. A GPU level write keeps only `cfg_data[1:0]`: 0 means none, 1 low, 2 medium and 3 high.
- R5: Among the active sources with nonzero priority, the one with the largest priority is selected.
- R6: When two or more eligible sources share the largest priority, the lowest index wins.
- R7: While a source is selected, `thr_active` is 1, `sel_idx` is its index, and `cpu_pct` and `gpu_lvl` are its stored settings.
- R8: When no source is eligible, `thr_active` is 0, and `sel_idx`, `cpu_pct` and `gpu_lvl` are all 0.
- R9: The outputs reflect `evt_act` as it was at the previous clock edge. A settings write accepted at edge k is visible on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_act | input | N_EVT | Active flag for each source (0 light, 1 heavy, 2 overcurrent) |
| cfg_valid | input | 1 | Write beat valid |
| cfg_ready | output | 1 | Write beat ready (high whenever not in reset) |
| cfg_evt | input | IDX_W | Source index for the write |
| cfg_field | input | 2 | Field select: 0 priority, 1 CPU depth, 2 GPU level, 3 no effect |
| cfg_data | input | DATA_W | Write value |
| thr_active | output | 1 | A source is selected |
| sel_idx | output | IDX_W | Index of the selected source |
| cpu_pct | output | 7 | CPU throttle depth in percent |
| gpu_lvl | output | 2 | GPU throttle level code |

## Verification
Changes on `evt_act` are due one edge after they are driven, and a write is due two edges after it is driven. The bench therefore drives inputs on the falling edge and waits for exactly one rising edge before it samples a response to an active-set change. A write task first returns at the falling edge that follows the accepting edge. At that point the bench checks that the outputs still hold their old values, and it checks again one edge later. A sweep over priority values {0, 1, 50, 100} for each source, with all eight active masks, covers ties, disabled sources and the idle case, and every expected value comes from the bench's own arithmetic model.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;

  localparam int PRIO_W   = 7;
  localparam int PCT_W    = 7;
  localparam int LVL_W    = 2;
  localparam int PRIO_MAX = 100;
  localparam int PCT_MAX  = 100;

  typedef enum logic [1:0] {
    FLD_PRIO = 2'd0,
    FLD_CPU  = 2'd1,
    FLD_GPU  = 2'd2,
    FLD_NONE = 2'd3
  } cfg_field_e;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [PCT_W-1:0]  cpu;
    logic [LVL_W-1:0]  gpu;
  } evt_cfg_t;

endpackage

// File: rtl/thr_cfg_bank.sv
module thr_cfg_bank
  import thr_arb_pkg::*;
#(
  parameter int N_EVT  = 3,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_evt,
  input  cfg_field_e              wr_field,
  input  logic [DATA_W-1:0]       wr_data,
  output evt_cfg_t [N_EVT-1:0]    cfg_q
);

  logic [PRIO_W-1:0] prio_sat;
  logic [PCT_W-1:0]  cpu_sat;
  logic [LVL_W-1:0]  gpu_val;

  always_comb begin
    if (wr_data > DATA_W'(PRIO_MAX)) prio_sat = PRIO_W'(PRIO_MAX);
    else                             prio_sat = wr_data[PRIO_W-1:0];
    if (wr_data > DATA_W'(PCT_MAX))  cpu_sat  = PCT_W'(PCT_MAX);
    else                             cpu_sat  = wr_data[PCT_W-1:0];
    gpu_val = wr_data[LVL_W-1:0];
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    logic hit;
    assign hit = wr_en && (wr_evt == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (hit) begin
        unique case (wr_field)
          FLD_PRIO: cfg_q[g].prio <= prio_sat;
          FLD_CPU:  cfg_q[g].cpu  <= cpu_sat;
          FLD_GPU:  cfg_q[g].gpu  <= gpu_val;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/thr_prio_pick.sv
module thr_prio_pick
  import thr_arb_pkg::*;
#(
  parameter int N_EVT = 3,
  parameter int IDX_W = 2
) (
  input  logic [N_EVT-1:0]        act,
  input  evt_cfg_t [N_EVT-1:0]    cfg,
  output logic                    hit,
  output logic [IDX_W-1:0]        win
);

  logic [PRIO_W-1:0] best;

  // Strict comparison: a later index must beat, not tie, the current best,
  // and a zero priority can never exceed the zero starting value.
  always_comb begin
    hit  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = 0; i < N_EVT; i++) begin
      if (act[i] && (cfg[i].prio > best)) begin
        best = cfg[i].prio;
        win  = IDX_W'(i);
        hit  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/thr_out_stage.sv
module thr_out_stage
  import thr_arb_pkg::*;
#(
  parameter int N_EVT = 3,
  parameter int IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit,
  input  logic [IDX_W-1:0]        win,
  input  evt_cfg_t [N_EVT-1:0]    cfg,
  output logic                    active_q,
  output logic [IDX_W-1:0]        idx_q,
  output logic [PCT_W-1:0]        cpu_q,
  output logic [LVL_W-1:0]        gpu_q
);

  evt_cfg_t sel_cfg;

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < N_EVT; i++) begin
      if (hit && (win == IDX_W'(i))) sel_cfg = cfg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      cpu_q    <= '0;
      gpu_q    <= '0;
    end else begin
      active_q <= hit;
      idx_q    <= hit ? win : '0;
      cpu_q    <= sel_cfg.cpu;
      gpu_q    <= sel_cfg.gpu;
    end
  end

endmodule

// File: rtl/thr_arb_top.sv
module thr_arb_top
  import thr_arb_pkg::*;
#(
  parameter int N_EVT  = 3,
  parameter int DATA_W = 8,
  localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVT-1:0]    evt_act,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [IDX_W-1:0]    cfg_evt,
  input  logic [1:0]          cfg_field,
  input  logic [DATA_W-1:0]   cfg_data,
  output logic                thr_active,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [PCT_W-1:0]    cpu_pct,
  output logic [LVL_W-1:0]    gpu_lvl
);

  evt_cfg_t [N_EVT-1:0] cfg_q;
  logic                 pick_hit;
  logic [IDX_W-1:0]     pick_win;
  logic                 wr_en;

  assign cfg_ready = rst_n;
  assign wr_en     = cfg_valid && cfg_ready;

  thr_cfg_bank #(.N_EVT(N_EVT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_evt   (cfg_evt),
    .wr_field (cfg_field_e'(cfg_field)),
    .wr_data  (cfg_data),
    .cfg_q    (cfg_q)
  );

  thr_prio_pick #(.N_EVT(N_EVT), .IDX_W(IDX_W)) u_pick (
    .act (evt_act),
    .cfg (cfg_q),
    .hit (pick_hit),
    .win (pick_win)
  );

  thr_out_stage #(.N_EVT(N_EVT), .IDX_W(IDX_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (pick_hit),
    .win      (pick_win),
    .cfg      (cfg_q),
    .active_q (thr_active),
    .idx_q    (sel_idx),
    .cpu_q    (cpu_pct),
    .gpu_q    (gpu_lvl)
  );

endmodule

// File: rtl/thr_arb_chk.sv
module thr_arb_chk #(
  parameter int N_EVT = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_act,
  input logic             thr_active,
  input logic [IDX_W-1:0] sel_idx,
  input logic [6:0]       cpu_pct,
  input logic [1:0]       gpu_lvl
);

  logic [N_EVT-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= evt_act;
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_active |-> (cpu_pct == '0 && gpu_lvl == '0 && sel_idx == '0));

  // R4
  cpu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pct <= 7'd100);

  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_act == '0) |=> !thr_active);

  // R7
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_active |-> act_q[sel_idx]);

  // R7
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_active |-> (int'(sel_idx) < N_EVT));

endmodule

bind thr_arb_top thr_arb_chk #(.N_EVT(N_EVT), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_act    (evt_act),
  .thr_active (thr_active),
  .sel_idx    (sel_idx),
  .cpu_pct    (cpu_pct),
  .gpu_lvl    (gpu_lvl)
);

// File: tb/tb_thr_arb_top.sv
module tb_thr_arb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt_act = '0;
  logic       cfg_valid = 1'b0;
  logic       cfg_ready;
  logic [1:0] cfg_evt = '0;
  logic [1:0] cfg_field = '0;
  logic [7:0] cfg_data = '0;
  logic       thr_active;
  logic [1:0] sel_idx;
  logic [6:0] cpu_pct;
  logic [1:0] gpu_lvl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_prio [3];
  int m_cpu  [3];
  int m_gpu  [3];

  always #10 clk = ~clk;

  thr_arb_top dut (
    .clk(clk), .rst_n(rst_n), .evt_act(evt_act),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_evt(cfg_evt),
    .cfg_field(cfg_field), .cfg_data(cfg_data),
    .thr_active(thr_active), .sel_idx(sel_idx),
    .cpu_pct(cpu_pct), .gpu_lvl(gpu_lvl)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Write one field; returns at the falling edge after the accepting edge.
  task automatic wr(int evt, int fld, int data);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_evt   = 2'(evt);
    cfg_field = 2'(fld);
    cfg_data  = 8'(data);
    @(negedge clk);
    cfg_valid = 1'b0;
    if (evt < 3) begin
      if (fld == 0) m_prio[evt] = (data > 100) ? 100 : data;
      if (fld == 1) m_cpu[evt]  = (data > 100) ? 100 : data;
      if (fld == 2) m_gpu[evt]  = data & 3;
    end
  endtask

  task automatic expect_out(string req, logic [2:0] mask);
    int best = 0;
    int win = 0;
    bit hit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (mask[i] && m_prio[i] > best) begin
        best = m_prio[i];
        win  = i;
        hit  = 1'b1;
      end
    end
    chk({req, " active"}, int'(thr_active), int'(hit));
    chk({req, " idx"},    int'(sel_idx),    hit ? win : 0);
    chk({req, " cpu"},    int'(cpu_pct),    hit ? m_cpu[win] : 0);
    chk({req, " gpu"},    int'(gpu_lvl),    hit ? m_gpu[win] : 0);
  endtask

  // Drive a mask at a falling edge, let one rising edge pass, then sample.
  task automatic apply(string req, logic [2:0] mask);
    @(negedge clk);
    evt_act = mask;
    @(posedge clk);
    @(negedge clk);
    expect_out(req, mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int pv [4] = '{0, 1, 50, 100};
    for (int i = 0; i < 3; i++) begin
      m_prio[i] = 0; m_cpu[i] = 0; m_gpu[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 active", int'(thr_active), 0);
    chk("R1 cpu", int'(cpu_pct), 0);
    chk("R1 gpu", int'(gpu_lvl), 0);
    chk("R1 idx", int'(sel_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready", int'(cfg_ready), 1);
    // R1: unconfigured sources do not throttle
    apply("R1 unconfigured", 3'b111);

    // Per-source settings: light 50%/low, heavy 85%/high, overcurrent 75%/medium
    wr(0, 1, 50); wr(0, 2, 1);
    wr(1, 1, 85); wr(1, 2, 3);
    wr(2, 1, 75); wr(2, 2, 2);

    // R5 R6 R7 R8 R3: sweep priorities x all masks
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          wr(0, 0, pv[a]); wr(1, 0, pv[b]); wr(2, 0, pv[c]);
          for (int m = 0; m < 8; m++) apply("R5_R6_R7_R8 sweep", 3'(m));
        end

    // R3: saturation of priority, tie at 100 goes to lowest index (R6)
    wr(0, 0, 100); wr(1, 0, 127); wr(2, 0, 0);
    apply("R3 sat tie", 3'b011);
    chk("R6 tie idx", int'(sel_idx), 0);
    apply("R3 sat alone", 3'b010);
    chk("R3 sat idx", int'(sel_idx), 1);
    apply("R3 zero disables", 3'b100);
    chk("R3 zero active", int'(thr_active), 0);

    // R4: cpu saturation and gpu low-bit keep
    wr(2, 0, 30); wr(2, 1, 120); wr(2, 2, 8'hFE);
    apply("R4 clamp", 3'b100);
    chk("R4 cpu clamp", int'(cpu_pct), 100);
    chk("R4 gpu bits", int'(gpu_lvl), 2);

    // R2: reserved field and out-of-range index have no effect
    wr(2, 3, 5);
    wr(3, 0, 100);
    wr(3, 1, 3);
    apply("R2 ignored", 3'b100);
    chk("R2 cpu kept", int'(cpu_pct), 100);
    chk("R2 gpu kept", int'(gpu_lvl), 2);

    // R9: write latency - old value one edge after accept, new after next
    wr(2, 1, 40);
    chk("R9 write old", int'(cpu_pct), 100);
    @(negedge clk);
    chk("R9 write new", int'(cpu_pct), 40);
    // R9: input latency - unchanged before the edge, updated after it
    evt_act = 3'b000;
    #2;
    chk("R9 mask before edge", int'(thr_active), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 mask after edge", int'(thr_active), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule